// File: doc/BRIEF.md
# Modbus ASCII LRC Generator and Checker

This block computes the longitudinal redundancy check used to protect Modbus ASCII frames. Binary message bytes, from the address byte through the final data byte, arrive one per accepted cycle on a valid/last stream. The block keeps an 8-bit running total of these bytes and drops every carry out of the top bit. When the byte marked last is accepted, the block registers the two's-complement negation of that total. It also presents the result as two uppercase ASCII hexadecimal characters, ready to hand to a transmitter.

In check mode the stream ends with the LRC byte that came with a received frame. That byte is added to the total like the others. A frame whose stored LRC is correct brings the total to zero, and this raises a pass flag together with the result strobe. A clear input drops a partial total. The total also returns to zero by itself after each frame, so frames can follow one another with no gap and no clear.

Top module: `lrc_engine`

## Requirements
- R1: After reset, res_valid and lrc_ok are 0, lrc_out is 00H and hex_out is 3030H (two ASCII '0' characters).
- R2: The running total is the sum, modulo 256, of every byte accepted since the frame began. Any carry out of bit 7 is discarded.
- R3: lrc_out is the two's-complement negation of the frame total. For the bytes 01H, 03H, 21H, 02H, 00H, 02H the result is D7H.
- R4: res_valid is high for exactly one cycle: the cycle after the byte with in_last=1 is accepted. Between result strobes, lrc_out, hex_out and lrc_ok keep their values, except that lrc_ok is 0 whenever res_valid is 0.
- R5: hex_out[15:8] holds the ASCII character for the high nibble of lrc_out and hex_out[7:0] holds the character for the low nibble. Nibble values 0-9 map to 30H-39H and values 10-15 map to 41H-46H (uppercase A-F).
- R6: chk_mode is sampled together with the last byte. When it is 1, that byte is the received LRC and is included in the total. lrc_ok is then 1 with res_valid when the total modulo 256 is 00H, and 0 otherwise. When chk_mode is 0, lrc_ok stays 0.
- R7: clear=1 discards the running total. A byte accepted in the same cycle as clear becomes the first byte of a new frame.
- R8: After the last byte of a frame is accepted, the total restarts at 00H without any clear.
- R9: While in_valid is 0, in_data, in_last and chk_mode have no effect on the total or on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Discard the running total |
| in_valid | input | 1 | in_data holds a byte to accept this cycle |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Marks the final byte of a frame |
| chk_mode | input | 1 | 1: the last byte is a received LRC to verify |
| res_valid | output | 1 | One-cycle strobe, result updated |
| lrc_out | output | 8 | Negated frame total |
| lrc_ok | output | 1 | Check passed (check mode, with res_valid) |
| hex_out | output | 16 | lrc_out as two ASCII hex characters, high nibble in the upper byte |

## Verification
The hardest situation to reach is a clear and a byte arriving in the same cycle, while a partial total is still held. The bench loads a non-zero partial total first and only then issues the combined clear and last-byte cycle, so a wrong priority shows up in the result. Full sweeps cover every single-byte frame and every received-LRC value, both correct and off by one, in check mode. Frames of pseudo-random length and content check carry loss and the automatic restart between frames.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
    localparam logic [7:0] ASCII_DIGIT_BASE = 8'h30;
    localparam logic [7:0] ASCII_ALPHA_BASE = 8'h37;
    localparam int         NIBBLE_W         = 4;
    localparam int         CHAR_W           = 8;
endpackage

// File: rtl/lrc_hex_digit.sv
module lrc_hex_digit
    import lrc_pkg::*;
(
    input  logic [NIBBLE_W-1:0] nib,
    output logic [CHAR_W-1:0]   chr
);
    logic [CHAR_W-1:0] nib_ext;

    always_comb begin
        nib_ext = {{(CHAR_W-NIBBLE_W){1'b0}}, nib};
        if (nib < NIBBLE_W'(10)) begin
            chr = ASCII_DIGIT_BASE + nib_ext;
        end else begin
            chr = ASCII_ALPHA_BASE + nib_ext;
        end
    end
endmodule

// File: rtl/lrc_sum_stage.sv
module lrc_sum_stage #(
    parameter int W = 8
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] addend,
    output logic [W-1:0] total,
    output logic         total_zero
);
    // Carry out of the top bit falls away with the W-bit result.
    always_comb begin
        total      = base + addend;
        total_zero = (total == '0);
    end
endmodule

// File: rtl/lrc_engine.sv
module lrc_engine
    import lrc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    in_valid,
    input  logic [W-1:0]            in_data,
    input  logic                    in_last,
    input  logic                    chk_mode,
    output logic                    res_valid,
    output logic [W-1:0]            lrc_out,
    output logic                    lrc_ok,
    output logic [(W/NIBBLE_W)*CHAR_W-1:0] hex_out
);
    localparam int NIB_CNT = W / NIBBLE_W;

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] res;
        logic         done;
        logic         ok;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] base_d;
    logic [W-1:0] total_d;
    logic         total_zero_d;

    // A clear drops the held total; an accepted byte then builds on zero.
    assign base_d = clear ? '0 : st_q.acc;

    lrc_sum_stage #(.W(W)) u_sum (
        .base       (base_d),
        .addend     (in_data),
        .total      (total_d),
        .total_zero (total_zero_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.ok   = 1'b0;
        st_d.acc  = base_d;
        if (in_valid) begin
            if (in_last) begin
                st_d.res  = W'(0) - total_d;
                st_d.done = 1'b1;
                st_d.ok   = chk_mode && total_zero_d;
                st_d.acc  = '0;
            end else begin
                st_d.acc  = total_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.done;
    assign lrc_out   = st_q.res;
    assign lrc_ok    = st_q.ok;

    // One encoder per nibble; nibble g lands in character slot g.
    for (genvar g = 0; g < NIB_CNT; g++) begin : g_hex
        lrc_hex_digit u_digit (
            .nib (st_q.res[g*NIBBLE_W +: NIBBLE_W]),
            .chr (hex_out[g*CHAR_W +: CHAR_W])
        );
    end
endmodule

// File: rtl/lrc_engine_checker.sv
module lrc_engine_checker #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_last,
    input logic           chk_mode,
    input logic           res_valid,
    input logic [W-1:0]   lrc_out,
    input logic           lrc_ok,
    input logic [15:0]    hex_out
);
    function automatic logic is_hex_char(input logic [7:0] c);
        return ((c >= 8'h30) && (c <= 8'h39)) || ((c >= 8'h41) && (c <= 8'h46));
    endfunction

    a_r4_strobe_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> res_valid);

    a_r4_strobe_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_last));

    a_r4_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_last) |=> $stable(lrc_out));

    a_r5_ascii_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (is_hex_char(hex_out[15:8]) && is_hex_char(hex_out[7:0])));

    a_r6_ok_needs_check_mode: assert property (@(posedge clk) disable iff (!rst_n)
        lrc_ok |-> (res_valid && $past(chk_mode)));

    a_r6_ok_means_zero_total: assert property (@(posedge clk) disable iff (!rst_n)
        lrc_ok |-> (lrc_out == '0));
endmodule

bind lrc_engine lrc_engine_checker #(.W(W)) u_lrc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .chk_mode  (chk_mode),
    .res_valid (res_valid),
    .lrc_out   (lrc_out),
    .lrc_ok    (lrc_ok),
    .hex_out   (hex_out)
);

// File: tb/lrc_engine_bench.sv
module lrc_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        chk_mode = 1'b0;
    logic        res_valid;
    logic [7:0]  lrc_out;
    logic        lrc_ok;
    logic [15:0] hex_out;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lrc_engine u_lrc_engine (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .chk_mode(chk_mode),
        .res_valid(res_valid), .lrc_out(lrc_out), .lrc_ok(lrc_ok), .hex_out(hex_out)
    );

    function automatic logic [7:0] hex_char(input logic [3:0] n);
        return (n < 4'd10) ? (8'd48 + 8'(n)) : (8'd65 + 8'(n) - 8'd10);
    endfunction

    task automatic check(input logic cond, input string req, input int act, input int exp_v);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Present one byte for one cycle; the sample point afterwards is the negedge after the accepting edge.
    task automatic send(input logic [7:0] b, input logic lst, input logic md, input logic clr);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_last = lst; chk_mode = md; clear = clr;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; chk_mode = 1'b0; clear = 1'b0;
    endtask

    task automatic expect_result(input logic [7:0] e_lrc, input logic e_ok, input string req);
        check(res_valid === 1'b1, {req, " res_valid"}, int'(res_valid), 1);
        check(lrc_out === e_lrc, {req, " lrc_out"}, int'(lrc_out), int'(e_lrc));
        check(lrc_ok === e_ok, {req, " lrc_ok"}, int'(lrc_ok), int'(e_ok));
        check(hex_out === {hex_char(e_lrc[7:4]), hex_char(e_lrc[3:0])},
              {req, " R5 hex_out"}, int'(hex_out),
              int'({hex_char(e_lrc[7:4]), hex_char(e_lrc[3:0])}));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] sum;
        logic [7:0] lfsr;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(res_valid === 1'b0, "R1 res_valid", int'(res_valid), 0);
        check(lrc_out === 8'h00, "R1 lrc_out", int'(lrc_out), 0);
        check(lrc_ok === 1'b0, "R1 lrc_ok", int'(lrc_ok), 0);
        check(hex_out === 16'h3030, "R1 hex_out", int'(hex_out), 16'h3030);
        rst_n = 1'b1;

        // R3: worked example, sum 29H gives D7H
        send(8'h01, 0, 0, 0); send(8'h03, 0, 0, 0); send(8'h21, 0, 0, 0);
        send(8'h02, 0, 0, 0); send(8'h00, 0, 0, 0); send(8'h02, 1, 0, 0);
        expect_result(8'hD7, 1'b0, "R3 example");
        check(hex_out === 16'h4437, "R5 example chars D7", int'(hex_out), 16'h4437);

        // R4: strobe lasts one cycle and result holds
        @(negedge clk);
        check(res_valid === 1'b0, "R4 strobe one cycle", int'(res_valid), 0);
        check(lrc_out === 8'hD7, "R4 result held", int'(lrc_out), 8'hD7);

        // R3/R5/R8: every single-byte frame
        for (int b = 0; b < 256; b++) begin
            send(8'(b), 1, 0, 0);
            expect_result(8'(0 - b), 1'b0, "R3 R8 single byte");
        end

        // R6: check mode, correct and off-by-one received LRC for every byte
        for (int b = 0; b < 256; b++) begin
            send(8'(b), 0, 0, 0);
            send(8'(0 - b), 1, 1, 0);
            expect_result(8'h00, 1'b1, "R6 good lrc");
            send(8'(b), 0, 0, 0);
            send(8'(1 - b), 1, 1, 0);
            expect_result(8'hFF, 1'b0, "R6 bad lrc");
        end

        // R6: zero total without check mode does not flag ok
        send(8'h80, 0, 0, 0); send(8'h80, 1, 0, 0);
        expect_result(8'h00, 1'b0, "R6 generate mode no ok");

        // R2: carries discarded, FF+FF+03 = 01
        send(8'hFF, 0, 0, 0); send(8'hFF, 0, 0, 0); send(8'h03, 1, 0, 0);
        expect_result(8'hFF, 1'b0, "R2 carry dropped");

        // R7: clear alone drops a partial total
        send(8'h55, 0, 0, 0);
        @(negedge clk); clear = 1'b1; @(negedge clk); clear = 1'b0;
        send(8'h10, 1, 0, 0);
        expect_result(8'hF0, 1'b0, "R7 clear alone");

        // R7: clear together with a byte keeps that byte
        send(8'h77, 0, 0, 0);
        send(8'h20, 1, 0, 1);
        expect_result(8'hE0, 1'b0, "R7 clear with byte");

        // R9: idle inputs ignored
        send(8'h05, 0, 0, 0);
        held = lrc_out;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_data = 8'h99; in_last = 1'b1; chk_mode = 1'b1;
            @(negedge clk);
            check(res_valid === 1'b0, "R9 no strobe while idle", int'(res_valid), 0);
            check(lrc_out === held, "R9 result unchanged", int'(lrc_out), int'(held));
        end
        in_last = 1'b0; chk_mode = 1'b0;
        send(8'h06, 1, 0, 0);
        expect_result(8'hF5, 1'b0, "R9 total unaffected");

        // R2/R8: pseudo-random frames back to back
        lfsr = 8'hA5;
        for (int len = 1; len <= 24; len++) begin
            sum = 8'h00;
            for (int i = 0; i < len; i++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                sum = sum + lfsr;
                send(lfsr, (i == len - 1), 0, 0);
            end
            expect_result(8'(0 - sum), 1'b0, "R2 R8 random frame");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule